// File: doc/BRIEF.md
# Indexed Block-Transfer Register Slave

This block is a two-wire serial slave holding sixteen 8-bit configuration registers. A host reaches them with two indexed block transfers. To write, the host addresses the slave for writing, sends a starting index, then a byte count, then that many data bytes. These are stored at ascending indices. To read, the host writes a starting index, issues a repeated start and addresses the slave for reading. The slave answers with the contents of its count register, then streams registers from the index onward until the host stops acknowledging. A parallel port shows the whole register image to the surrounding logic at all times.

The clock and data lines pass through two-flop synchronizers into a system clock at least eight times the bus clock. An edge detector derives the bus-clock edges and the start and stop conditions. The slave samples data on the bus-clock rise and drives the data line, open-drain, only while the bus clock is low.

The controller has twelve states:
- `S_IDLE`: waiting for a start.
- `S_ADDR`: shifting in the address byte.
- `S_ADDR_ACK`: acknowledging the address.
- `S_IDX`: shifting in the index.
- `S_IDX_ACK`: acknowledging the index.
- `S_CNT`: shifting in the count.
- `S_CNT_ACK`: acknowledging the count.
- `S_WDATA`: shifting in a data byte.
- `S_DATA_ACK`: acknowledging a data byte.
- `S_TX`: sending a byte.
- `S_TX_ACK`: sampling the host acknowledge.
- `S_IGNORE`: deaf until the next start.

The transitions are:
- A stop moves any state to `S_IDLE`, and a start moves any state to `S_ADDR`.
- At the end of a byte, `S_ADDR` goes to `S_ADDR_ACK` on a match and to `S_IGNORE` otherwise.
- `S_ADDR_ACK` goes to `S_TX` for a read and to `S_IDX` for a write.
- The write path runs `S_IDX` → `S_IDX_ACK` → `S_CNT` → `S_CNT_ACK` → `S_WDATA`.
- `S_WDATA` goes to `S_DATA_ACK` while the remaining count is non-zero and to `S_IGNORE` otherwise. `S_DATA_ACK` returns to `S_WDATA`.
- `S_TX` goes to `S_TX_ACK`. `S_TX_ACK` returns to `S_TX` on a host ACK and goes to `S_IGNORE` on a NACK.

Top module: `smb_blkreg_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). Any other address byte is left unacknowledged, and every following byte is also unacknowledged until the next start condition.
- R2: In a write, the byte after the address is the index and the next is the count X. The next X data bytes are each acknowledged and stored at ascending register indices from the index.
- R3: The index is taken modulo 16, and the register pointer wraps from 15 to 0 in both writes and reads.
- R4: Data bytes beyond the count X of a write are not acknowledged and not stored.
- R5: Register 15 is read-only with the fixed value 0xA5. A write to it is acknowledged and consumes a count slot, but leaves the value unchanged.
- R6: After an index write, a repeated start and address 0xD3, the slave sends the value of register 8 first. It then sends the registers from the pointer in ascending order.
- R7: A host ACK after a sent byte makes the slave send the next byte. A host NACK makes it release SDA and stay silent until the next start.
- R8: Register 8 (the read count) is writable and resets to 0x03. Every other writable register resets to 0x00.
- R9: A start condition mid-transfer aborts it and begins a new address phase, with the register pointer kept. A stop returns the slave to idle. Bytes already stored are kept in both cases.
- R10: SDA driven by the slave changes only while SCL is low, so it is stable throughout each SCL high phase.
- R11: `regs_o` bits [8i+7:8i] always show register i.
- R12: `sda_oe` high pulls SDA low. It is asserted only during an acknowledge slot or a transmitted zero bit, and is low in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when high |
| regs_o | output | 128 | Register image, register i at bits [8i+7:8i] |

## Verification
A corrupted pointer or remaining count shows on `regs_o` within one system clock of the next stored byte. It also shows as a wrong returned byte within one byte time of a read. A controller stuck in the wrong state shows at the next acknowledge slot, at most nine SCL periods later, as a missing or extra pull-down on SDA. The bench compares the full register image against its own model on every clock and checks every acknowledge bit and every returned byte. It also checks that SDA holds still through each SCL high phase.

// File: rtl/smb_blkreg_pkg.sv
package smb_blkreg_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_IDX,
        S_IDX_ACK,
        S_CNT,
        S_CNT_ACK,
        S_WDATA,
        S_DATA_ACK,
        S_TX,
        S_TX_ACK,
        S_IGNORE
    } state_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    logic [LINES-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int          NUM_REGS  = 16,
    parameter int          IDX_W     = 4,
    parameter int          CNT_IDX   = 8,
    parameter logic [7:0]  CNT_RESET = 8'h03,
    parameter logic [31:0] RO_MASK   = 32'h0000_8000,
    parameter logic [7:0]  RO_VALUE  = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [7:0]            cnt_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (RO_MASK[i]) begin : g_ro
            assign regs_o[i*8 +: 8] = RO_VALUE;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= (i == CNT_IDX) ? CNT_RESET : 8'h00;
                else if (wr_en && wr_idx == IDX_W'(i))
                    q <= wr_data;
            end
            assign regs_o[i*8 +: 8] = q;
        end
    end

    assign rd_data = regs_o[rd_idx*8 +: 8];
    assign cnt_o   = regs_o[CNT_IDX*8 +: 8];
endmodule

// File: rtl/smb_blkreg_slave.sv
module smb_blkreg_slave
    import smb_blkreg_pkg::*;
#(
    parameter int          NUM_REGS  = 16,
    parameter logic [6:0]  DEV_ADDR  = 7'h69,
    parameter int          CNT_IDX   = 8,
    parameter logic [7:0]  CNT_RESET = 8'h03,
    parameter logic [31:0] RO_MASK   = 32'h0000_8000,
    parameter logic [7:0]  RO_VALUE  = 8'hA5,
    parameter int          SYNC_STG  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int BIT_W = 4;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(8);

    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    state_t     state_q, state_d;
    logic [7:0] shreg_q, txsh_q, remain_q;
    logic [BIT_W-1:0] bitcnt_q;
    logic [IDX_W-1:0] ptr_q, ptr_inc;
    logic       rw_q, host_ack_q, sda_drv_q;
    logic       byte_end, wr_en, cap_rw, cap_idx, cap_cnt, load_cnt, load_tx;
    logic [7:0] rd_data, cnt_val, tx_next;

    smb_line_sync #(.LINES(2), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout({scl_s, sda_s})
    );

    smb_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_reg_bank #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CNT_IDX(CNT_IDX),
        .CNT_RESET(CNT_RESET), .RO_MASK(RO_MASK), .RO_VALUE(RO_VALUE)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr_q),
        .wr_data(shreg_q), .rd_idx(ptr_q), .rd_data(rd_data),
        .cnt_o(cnt_val), .regs_o(regs_o)
    );

    assign byte_end = scl_fall && (bitcnt_q == LAST_BIT);
    assign ptr_inc  = (ptr_q == IDX_W'(NUM_REGS-1)) ? '0 : ptr_q + 1'b1;
    assign tx_next  = load_cnt ? cnt_val : rd_data;

    // next-state and strobes
    always_comb begin
        state_d  = state_q;
        wr_en    = 1'b0;
        cap_rw   = 1'b0;
        cap_idx  = 1'b0;
        cap_cnt  = 1'b0;
        load_cnt = 1'b0;
        load_tx  = 1'b0;
        if (stop_det) begin
            state_d = S_IDLE;
        end else if (start_det) begin
            state_d = S_ADDR;
        end else begin
            unique case (state_q)
                S_IDLE, S_IGNORE: ;
                S_ADDR: if (byte_end) begin
                    if (shreg_q[7:1] == DEV_ADDR) begin
                        state_d = S_ADDR_ACK;
                        cap_rw  = 1'b1;
                    end else begin
                        state_d = S_IGNORE;
                    end
                end
                S_ADDR_ACK: if (scl_fall) begin
                    state_d  = rw_q ? S_TX : S_IDX;
                    load_cnt = rw_q;
                end
                S_IDX: if (byte_end) begin
                    state_d = S_IDX_ACK;
                    cap_idx = 1'b1;
                end
                S_IDX_ACK: if (scl_fall) state_d = S_CNT;
                S_CNT: if (byte_end) begin
                    state_d = S_CNT_ACK;
                    cap_cnt = 1'b1;
                end
                S_CNT_ACK: if (scl_fall) state_d = S_WDATA;
                S_WDATA: if (byte_end) begin
                    if (remain_q != 8'd0) begin
                        state_d = S_DATA_ACK;
                        wr_en   = 1'b1;
                    end else begin
                        state_d = S_IGNORE;
                    end
                end
                S_DATA_ACK: if (scl_fall) state_d = S_WDATA;
                S_TX: if (byte_end) state_d = S_TX_ACK;
                S_TX_ACK: if (scl_fall) begin
                    if (host_ack_q) begin
                        state_d = S_TX;
                        load_tx = 1'b1;
                    end else begin
                        state_d = S_IGNORE;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs: open-drain pull-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_drv_q <= 1'b0;
        end else begin
            unique case (state_d)
                S_ADDR_ACK, S_IDX_ACK, S_CNT_ACK, S_DATA_ACK: sda_drv_q <= 1'b1;
                S_TX: begin
                    if (load_cnt || load_tx) sda_drv_q <= ~tx_next[7];
                    else if (scl_fall)       sda_drv_q <= ~txsh_q[6];
                end
                default: sda_drv_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe = sda_drv_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            txsh_q     <= '0;
            bitcnt_q   <= '0;
            ptr_q      <= '0;
            remain_q   <= '0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
        end else begin
            if (start_det || state_d != state_q)
                bitcnt_q <= '0;
            else if (scl_rise && bitcnt_q != LAST_BIT &&
                     (state_q == S_ADDR || state_q == S_IDX || state_q == S_CNT ||
                      state_q == S_WDATA || state_q == S_TX))
                bitcnt_q <= bitcnt_q + 1'b1;

            if (scl_rise) shreg_q <= {shreg_q[6:0], sda_s};
            if (cap_rw)   rw_q    <= shreg_q[0];
            if (cap_idx)  ptr_q   <= IDX_W'(shreg_q % NUM_REGS);
            else if (wr_en || load_tx) ptr_q <= ptr_inc;
            if (cap_cnt)  remain_q <= shreg_q;
            else if (wr_en) remain_q <= remain_q - 8'd1;

            if (state_q == S_TX_ACK && scl_rise) host_ack_q <= ~sda_s;

            if (load_cnt || load_tx)
                txsh_q <= tx_next;
            else if (state_q == S_TX && scl_fall && !byte_end)
                txsh_q <= {txsh_q[6:0], 1'b0};
        end
    end
endmodule

// File: rtl/smb_blkreg_chk.sv
module smb_blkreg_chk
    import smb_blkreg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  start_det,
    input logic                  stop_det,
    input state_t                state_q,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] regs_o
);
    // R10
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R12
    quiet_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE || state_q == S_IGNORE || state_q == S_TX_ACK) |-> !sda_oe);

    // R12
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state_q == S_ADDR_ACK || state_q == S_IDX_ACK ||
                    state_q == S_CNT_ACK || state_q == S_DATA_ACK || state_q == S_TX));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state_q == S_IDLE);

    // R9
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> state_q == S_ADDR);

    // R2
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(state_q) == S_WDATA);
endmodule

bind smb_blkreg_slave smb_blkreg_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .state_q(state_q), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/smb_blkreg_slave_bench.sv
`timescale 1ns/1ps
module smb_blkreg_slave_bench;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_low = 1'b0;
    logic sda_oe;
    logic [127:0] regs_o;
    wire  sda_bus = !(sda_low || sda_oe);

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit fin = 1'b0;
    logic [7:0] model [16];
    int mptr = 0;
    logic [7:0] wdat [$];

    always #10 clk = ~clk;

    smb_blkreg_slave u_smb_blkreg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
        .sda_oe(sda_oe), .regs_o(regs_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R11: full register image against the model on every clock
    always @(negedge clk) begin
        if (rst_n && cmp_en && !fin) begin
            logic [127:0] e;
            for (int i = 0; i < 16; i++) e[i*8 +: 8] = model[i];
            checks++;
            if (regs_o !== e) begin
                errors++;
                $display("FAIL R11 register image actual %h expected %h", regs_o, e);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        wq(); sda_low = 1'b1; wq(); scl_h = 1'b0;
    endtask

    task automatic bus_rstart();
        wq(); sda_low = 1'b0; wq(); scl_h = 1'b1; wq(); sda_low = 1'b1; wq(); scl_h = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); sda_low = 1'b1; wq(); scl_h = 1'b1; wq(); sda_low = 1'b0; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_low = !b[i]; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0;
        end
        wq(); sda_low = 1'b0; wq(); scl_h = 1'b1; wq();
        a = !sda_bus;
        wq(); scl_h = 1'b0;
        chk(req, int'(a), int'(exp_ack));
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        logic s1, s2;
        sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(); wq(); scl_h = 1'b1; wq();
            s1 = sda_bus;
            wq();
            s2 = sda_bus;
            scl_h = 1'b0;
            chk("R10 SDA steady while SCL high", int'(s2), int'(s1));
            b[i] = s1;
        end
        wq(); sda_low = ack; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0; wq();
        sda_low = 1'b0;
    endtask

    // block write from wdat; data past cnt expect NACK (R4)
    task automatic wr_block(input int idx, input int cnt, input bit do_stop);
        bus_start();
        send_byte(8'hD2, 1'b1, "R1 write address ack");
        send_byte(8'(idx), 1'b1, "R2 index ack");
        mptr = idx % 16;
        send_byte(8'(cnt), 1'b1, "R2 count ack");
        for (int k = 0; k < wdat.size(); k++) begin
            bit exp = (k < cnt);
            cmp_en = 1'b0;
            if (!exp)            send_byte(wdat[k], 1'b0, "R4 excess byte nack");
            else if (mptr == 15) send_byte(wdat[k], 1'b1, "R5 read-only write ack");
            else                 send_byte(wdat[k], 1'b1, "R2 data ack");
            if (exp) begin
                if (mptr != 15) model[mptr] = wdat[k];
                mptr = (mptr + 1) % 16;
            end
            cmp_en = 1'b1;
        end
        if (do_stop) bus_stop();
    endtask

    // mode 0: full indexed read, 2: repeated start straight to read address
    task automatic rd_block(input int mode, input int idx, input int n);
        logic [7:0] b;
        if (mode == 0) begin
            bus_start();
            send_byte(8'hD2, 1'b1, "R6 write address ack");
            send_byte(8'(idx), 1'b1, "R6 index ack");
            mptr = idx % 16;
        end
        bus_rstart();
        send_byte(8'hD3, 1'b1, "R6 read address ack");
        recv_byte(n > 0, b);
        chk(mode == 0 ? "R6 count byte" : "R9 count byte after abort", int'(b), int'(model[8]));
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(mode == 0 ? "R6 R3 data byte" : "R9 data byte after abort",
                int'(b), int'(model[mptr]));
            mptr = (mptr + 1) % 16;
        end
        chk("R7 SDA released after NACK", int'(sda_oe), 0);
        bus_stop();
        chk("R12 SDA released in idle", int'(sda_oe), 0);
    endtask

    task automatic finish_run();
        if (!fin) begin
            fin = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model[8]  = 8'h03;
        model[15] = 8'hA5;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk("R8 count register reset", int'(regs_o[71:64]), 8'h03);
        chk("R8 plain register reset", int'(regs_o[7:0]), 8'h00);
        chk("R5 read-only value", int'(regs_o[127:120]), 8'hA5);
        chk("R12 no drive after reset", int'(sda_oe), 0);
        cmp_en = 1'b1;

        // R2 then R6/R7 back to back
        wdat = '{8'h11, 8'h22, 8'h33};
        wr_block(2, 3, 1'b1);
        rd_block(0, 2, 3);

        // R8 program count, then R3/R5 wrap read
        wdat = '{8'h05};
        wr_block(8, 1, 1'b1);
        rd_block(0, 14, 5);

        // R3 R5 write across read-only and wrap
        wdat = '{8'h44, 8'h55, 8'h66};
        wr_block(14, 3, 1'b1);
        chk("R3 wrapped write to register 0", int'(regs_o[7:0]), 8'h66);
        chk("R5 read-only unchanged", int'(regs_o[127:120]), 8'hA5);

        // R3 index modulo 16
        wdat = '{8'h77};
        wr_block(8'h13, 1, 1'b1);
        chk("R3 index 0x13 lands on 3", int'(regs_o[31:24]), 8'h77);

        // R4 excess byte
        wdat = '{8'h88, 8'h99};
        wr_block(10, 1, 1'b1);
        chk("R4 excess byte not stored", int'(regs_o[95:88]), 8'h00);

        // R1 foreign address
        bus_start();
        send_byte(8'hA0, 1'b0, "R1 foreign address nack");
        send_byte(8'h01, 1'b0, "R1 ignored byte nack");
        bus_stop();
        wdat = '{8'hD3};
        wr_block(12, 1, 1'b1);

        // R9 abort by repeated start, pointer kept
        wdat = '{8'h9A};
        wr_block(5, 3, 1'b0);
        chk("R9 byte before abort kept", int'(regs_o[47:40]), 8'h9A);
        rd_block(2, 0, 2);

        // R9 abort by stop
        wdat = '{8'h3C};
        wr_block(9, 2, 1'b0);
        bus_stop();
        chk("R9 byte before stop kept", int'(regs_o[79:72]), 8'h3C);

        // R7 NACK straight after the count byte
        rd_block(0, 0, 0);
        rd_block(0, 1, 4);

        repeat (10) @(posedge clk);
        finish_run();
    end
endmodule